// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block keeps wall-clock time and a calendar date as packed BCD bytes. It advances them once per second. The one-second step comes from an internal prescaler that counts pulses on `baseTick`. A byte-wide register port gives read and write access to every field. The port has an address, write data, a write strobe and a combinational read path. Writes to the seven time fields take effect only while a write-enable bit in a control byte is set. The control byte can always be written.

The hours byte has a mode flag in bit 7.
- With the flag set, hours count from 00 to 23.
- With the flag clear, hours count from 12 through 11. Bit 5 marks the afternoon.

A step ripples from seconds to minutes, hours and date. The date then rolls over at the month's last day and carries into the month. The month carries into a two-digit year that spans 2000 to 2099. The leap-year rule is exact over that span. A binary day-of-week counter steps each time the date does.

Top module: `bcd_calendar_regs`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00, minutes 0x00, hours 0x80 (24-hour, hour 00), date 0x01, month 0x01, year 0x00, day of week 0x00, control 0x00.
- R2: Address map: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 8 control. Control bit 6 is the write enable. A write to addresses 0 to 6 changes nothing while that bit is 0. A write to address 8 always takes effect, and only bit 6 is kept.
- R3: Seconds step from 0x59 to 0x00 and carry into minutes. Minutes step from 0x59 to 0x00 and carry into hours.
- R4: With hours bit 7 set (24-hour), the hour field steps from 0x23 to 0x00 and carries into the date. Bit 7 is never changed by a time step.
- R5: With hours bit 7 clear (12-hour), bits 4:0 hold BCD 01 to 12 and bit 5 is the PM flag. The step from 11 goes to 12 and toggles PM. The step from 12 goes to 01. Only the step from 11 PM to 12 AM carries into the date.
- R6: The date wraps to 0x01 after 0x30 in April, June, September and November, and after 0x31 in the other long months. The month wraps from 0x12 to 0x01 and carries into the year.
- R7: February has 29 days when the BCD year is divisible by 4 (including 00) and 28 days otherwise.
- R8: Day of week counts 0 to 6 in binary and wraps to 0. It steps exactly when the date steps.
- R9: The time steps once every TICKS_PER_SEC `baseTick` pulses. An accepted time-field write restarts that count, so the next step needs a full TICKS_PER_SEC pulses.
- R10: Field widths are: seconds and minutes 7 bits, hours bits 7 and 5:0, date 6 bits, month 5 bits, year 8 bits, day of week 3 bits. Written bits outside a field read back as 0. Unmapped addresses read 0.
- R11: The year steps from 0x99 to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | One-cycle pulse; TICKS_PER_SEC pulses make one second |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |

## Verification
The step logic takes for granted that the host writes only legal BCD values, in range for their field and for the current month. An out-of-range byte is still stepped by the BCD increment and is not repaired. The stimulus writes illegal patterns only to test the masks of R10, and it rewrites the field with a legal value before any step. `baseTick` is assumed to be a single-cycle pulse, and the bench drives it that way.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam logic [3:0] CTRL_ADDR = 4'd8;
  localparam int WE_BIT = 6;

  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] wrField;
    logic                  ctrlWr;
  } cal_strobe_t;

  localparam logic [7:0] FIELD_MASK [NUM_FIELDS] =
    '{8'h7F, 8'h7F, 8'hBF, 8'h3F, 8'h1F, 8'hFF, 8'h07};
  localparam logic [7:0] FIELD_RST [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00};

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [7:0] yr);
    logic oddTens;
    oddTens = yr[4];
    if (oddTens) return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02: return isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
`timescale 1ns/1ps
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output cal_strobe_t       stb,
  output logic              weBit
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic timeAddr, acceptWr;

  assign timeAddr = (addr < ADDR_W'(NUM_FIELDS));
  assign acceptWr = wrEn && timeAddr && weBit;

  always_comb begin
    stb = '0;
    stb.ctrlWr  = wrEn && (addr == ADDR_W'(CTRL_ADDR));
    stb.advance = baseTick && (phaseCnt == CNT_LAST) && !acceptWr;
    for (int i = 0; i < NUM_FIELDS; i++)
      stb.wrField[i] = acceptWr && (addr == ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weBit    <= 1'b0;
      phaseCnt <= '0;
    end else begin
      if (stb.ctrlWr) weBit <= wrData[WE_BIT];
      if (acceptWr) phaseCnt <= '0;
      else if (baseTick) phaseCnt <= (phaseCnt == CNT_LAST) ? '0 : phaseCnt + 1'b1;
    end
  end

  // R2: a locked bus never produces a field write strobe
  p_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && timeAddr && !weBit) |-> (stb.wrField == '0));
  // R2: at most one field is written per cycle
  p_onehot_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.wrField));
  // R9: a time step and a host time write never coincide
  p_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrField != '0) |-> !stb.advance);
  // R9: steps are at least one tick period apart
  p_spacing_r9: assert property (@(posedge clk) disable iff (!rstN)
    (TICKS_PER_SEC > 1 && stb.advance) |=> !stb.advance);
endmodule

// File: rtl/cal_data.sv
`timescale 1ns/1ps
module cal_data
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cal_strobe_t       stb,
  input  logic              weBit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);
  logic [7:0] fieldQ  [NUM_FIELDS];
  logic [7:0] stepVal [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] stepEn;

  logic [7:0] secQ, minQ, hourQ, dateQ, monQ, yearQ, dowQ;
  assign secQ  = fieldQ[0];
  assign minQ  = fieldQ[1];
  assign hourQ = fieldQ[2];
  assign dateQ = fieldQ[3];
  assign monQ  = fieldQ[4];
  assign yearQ = fieldQ[5];
  assign dowQ  = fieldQ[6];

  logic secWrap, minWrap, hourWrap, dateWrap, monWrap;
  logic is24, pmFlag;
  logic [4:0] hr12;
  logic dayCarry;

  assign is24     = hourQ[7];
  assign pmFlag   = hourQ[5];
  assign hr12     = hourQ[4:0];
  assign secWrap  = (secQ == 8'h59);
  assign minWrap  = (minQ == 8'h59);
  assign hourWrap = is24 ? (hourQ[5:0] == 6'h23) : (hr12 == 5'h11 && pmFlag);
  assign dateWrap = (dateQ == lastDay(monQ, yearQ));
  assign monWrap  = (monQ == 8'h12);
  assign dayCarry = secWrap && minWrap && hourWrap;

  always_comb begin
    stepEn[0] = 1'b1;
    stepEn[1] = secWrap;
    stepEn[2] = secWrap && minWrap;
    stepEn[3] = dayCarry;
    stepEn[4] = dayCarry && dateWrap;
    stepEn[5] = dayCarry && dateWrap && monWrap;
    stepEn[6] = dayCarry;

    stepVal[0] = secWrap ? 8'h00 : bcdInc(secQ);
    stepVal[1] = minWrap ? 8'h00 : bcdInc(minQ);
    if (is24)
      stepVal[2] = (hourQ[5:0] == 6'h23) ? 8'h80 : {2'b10, 6'(bcdInc({2'b00, hourQ[5:0]}))};
    else if (hr12 == 5'h11)
      stepVal[2] = {2'b00, ~pmFlag, 5'h12};
    else if (hr12 == 5'h12)
      stepVal[2] = {2'b00, pmFlag, 5'h01};
    else
      stepVal[2] = {2'b00, pmFlag, 5'(bcdInc({3'b000, hr12}))};
    stepVal[3] = dateWrap ? 8'h01 : bcdInc(dateQ);
    stepVal[4] = monWrap ? 8'h01 : bcdInc(monQ);
    stepVal[5] = (yearQ == 8'h99) ? 8'h00 : bcdInc(yearQ);
    stepVal[6] = (dowQ == 8'h06) ? 8'h00 : dowQ + 8'h01;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    always_ff @(posedge clk) begin
      if (!rstN) fieldQ[g] <= FIELD_RST[g];
      else if (stb.wrField[g]) fieldQ[g] <= wrData & FIELD_MASK[g];
      else if (stb.advance && stepEn[g]) fieldQ[g] <= stepVal[g];
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (addr < ADDR_W'(NUM_FIELDS)) rdData = fieldQ[addr[2:0]];
    else if (addr == ADDR_W'(CTRL_ADDR)) rdData = {1'b0, weBit, 6'b0};
  end

  // R3: seconds wrap to zero on a step from 59
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && secQ == 8'h59) |=> (secQ == 8'h00));
  // R4: a time step keeps the hour mode flag
  p_mode_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (hourQ[7] == $past(hourQ[7])));
  // R8: day of week wraps from 6 to 0 on a date step
  p_dow_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && dayCarry && dowQ == 8'h06) |=> (dowQ == 8'h00));
  // R11: year wraps from 99 to 00
  p_year_wrap_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && stepEn[5] && yearQ == 8'h99) |=> (yearQ == 8'h00));
  // R10: the unused top bit of the seconds field reads as 0
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (addr == '0) |-> !rdData[7]);
endmodule

// File: rtl/bcd_calendar_regs.sv
`timescale 1ns/1ps
module bcd_calendar_regs #(
  parameter int TICKS_PER_SEC = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);
  cal_pkg::cal_strobe_t stb;
  logic weBit;

  cal_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .stb(stb), .weBit(weBit));

  cal_data #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .weBit(weBit), .addr(addr),
    .wrData(wrData), .rdData(rdData));
endmodule

// File: tb/bcd_calendar_regs_test.sv
`timescale 1ns/1ps
module bcd_calendar_regs_test;
  localparam int TPS = 4;
  logic clk = 1'b0, rstN = 1'b0, baseTick = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_calendar_regs #(.TICKS_PER_SEC(TPS), .ADDR_W(4)) uut (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData));

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    addr = a; #1;
    checks++;
    if (rdData !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rdData, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); baseTick = 1'b1;
      @(negedge clk); baseTick = 1'b0;
    end
  endtask

  task automatic setTime(input logic [7:0] yr, mo, dt, hr, mn, sc, dw);
    wr(4'd8, 8'h40);
    wr(4'd5, yr); wr(4'd4, mo); wr(4'd3, dt); wr(4'd2, hr);
    wr(4'd1, mn); wr(4'd6, dw); wr(4'd0, sc);
  endtask

  task automatic testReset();
    chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h80, "R1");
    chk(3, 8'h01, "R1"); chk(4, 8'h01, "R1"); chk(5, 8'h00, "R1");
    chk(6, 8'h00, "R1"); chk(8, 8'h00, "R1");
  endtask

  task automatic testLock();
    wr(4'd0, 8'h30); chk(0, 8'h00, "R2 locked sec");
    wr(4'd5, 8'h42); chk(5, 8'h00, "R2 locked year");
    wr(4'd8, 8'hFF); chk(8, 8'h40, "R2 ctrl keeps bit6 only");
    wr(4'd0, 8'h30); chk(0, 8'h30, "R2 unlocked sec");
    wr(4'd8, 8'h00); wr(4'd0, 8'h12); chk(0, 8'h30, "R2 relocked sec");
  endtask

  task automatic testMasks();
    wr(4'd8, 8'h40);
    wr(4'd0, 8'hFF); chk(0, 8'h7F, "R10 sec mask");
    wr(4'd2, 8'hFF); chk(2, 8'hBF, "R10 hour mask");
    wr(4'd3, 8'hFF); chk(3, 8'h3F, "R10 date mask");
    wr(4'd4, 8'hFF); chk(4, 8'h1F, "R10 month mask");
    wr(4'd6, 8'hFF); chk(6, 8'h07, "R10 dow mask");
    chk(7, 8'h00, "R10 unmapped 7"); chk(15, 8'h00, "R10 unmapped 15");
    setTime(8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic testLeapRoll();
    setTime(8'h24, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h58, 8'h06);
    pulses(TPS); chk(0, 8'h59, "R3 sec step");
    pulses(TPS);
    chk(0, 8'h00, "R3 sec wrap"); chk(1, 8'h00, "R3 min wrap");
    chk(2, 8'h80, "R4 hour wrap"); chk(3, 8'h29, "R7 leap feb 29");
    chk(4, 8'h02, "R7 still feb"); chk(6, 8'h00, "R8 dow wrap");
    setTime(8'h24, 8'h02, 8'h29, 8'hA3, 8'h59, 8'h59, 8'h03);
    pulses(TPS); chk(3, 8'h01, "R7 leap end"); chk(4, 8'h03, "R7 march");
    chk(6, 8'h04, "R8 dow step");
    setTime(8'h23, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h59, 8'h00);
    pulses(TPS); chk(3, 8'h01, "R7 nonleap"); chk(4, 8'h03, "R7 nonleap march");
    setTime(8'h00, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h59, 8'h00);
    pulses(TPS); chk(3, 8'h29, "R7 year 00 leap");
    setTime(8'h00, 8'h01, 8'h01, 8'h85, 8'h59, 8'h59, 8'h02);
    pulses(TPS); chk(2, 8'h86, "R3 hour carry"); chk(3, 8'h01, "R4 no date carry");
    chk(6, 8'h02, "R8 dow holds");
  endtask

  task automatic testMonths();
    setTime(8'h10, 8'h04, 8'h30, 8'hA3, 8'h59, 8'h59, 8'h01);
    pulses(TPS); chk(3, 8'h01, "R6 april end"); chk(4, 8'h05, "R6 may");
    setTime(8'h10, 8'h01, 8'h30, 8'hA3, 8'h59, 8'h59, 8'h01);
    pulses(TPS); chk(3, 8'h31, "R6 jan 31");
    setTime(8'h10, 8'h11, 8'h30, 8'hA3, 8'h59, 8'h59, 8'h01);
    pulses(TPS); chk(4, 8'h12, "R6 nov end");
    setTime(8'h99, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59, 8'h05);
    pulses(TPS);
    chk(4, 8'h01, "R6 dec wrap"); chk(3, 8'h01, "R6 date");
    chk(5, 8'h00, "R11 year wrap"); chk(6, 8'h06, "R8 dow 6");
    setTime(8'h19, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59, 8'h05);
    pulses(TPS); chk(5, 8'h20, "R6 year carry");
  endtask

  task automatic test12h();
    setTime(8'h10, 8'h03, 8'h05, 8'h11, 8'h59, 8'h59, 8'h01);
    pulses(TPS); chk(2, 8'h32, "R5 11am to 12pm"); chk(3, 8'h05, "R5 no carry");
    setTime(8'h10, 8'h03, 8'h05, 8'h31, 8'h59, 8'h59, 8'h01);
    pulses(TPS); chk(2, 8'h12, "R5 11pm to 12am"); chk(3, 8'h06, "R5 date carry");
    setTime(8'h10, 8'h03, 8'h05, 8'h12, 8'h59, 8'h59, 8'h01);
    pulses(TPS); chk(2, 8'h01, "R5 12am to 1am");
    setTime(8'h10, 8'h03, 8'h05, 8'h32, 8'h59, 8'h59, 8'h01);
    pulses(TPS); chk(2, 8'h21, "R5 12pm to 1pm");
    setTime(8'h10, 8'h03, 8'h05, 8'h09, 8'h59, 8'h59, 8'h01);
    pulses(TPS); chk(2, 8'h10, "R5 9 to 10");
  endtask

  task automatic testPhase();
    setTime(8'h10, 8'h03, 8'h05, 8'h80, 8'h00, 8'h10, 8'h01);
    pulses(TPS - 1); chk(0, 8'h10, "R9 not yet");
    pulses(1); chk(0, 8'h11, "R9 one second");
    pulses(2); wr(4'd0, 8'h20);
    pulses(TPS - 1); chk(0, 8'h20, "R9 phase restarted");
    pulses(1); chk(0, 8'h21, "R9 full period");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLock();
    testMasks();
    testLeapRoll();
    testMonths();
    test12h();
    testPhase();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule